// File: doc/BRIEF.md
# Sticky Status Interrupt Controller

This block gathers event and error pulses from a multi-channel measurement front end into one 16-bit status word, and drives an active-low interrupt pin. A per-channel data-ready flag and a set of error-kind flags live in the status word, with a small field that names the channel of the first error seen. As soon as any pulse is captured the whole word freezes. Pulses that arrive while it is frozen are dropped. A software-visible mask word chooses which flags may pull the interrupt low, and a global disable bit holds the pin high whatever the mask says.

Software reaches the block through a plain register port: address, write data, write strobe, read strobe and one-cycle-late read data. Reading the status word returns it and wipes it. A side strobe from the channel data path marks a read of a channel's data-MSB register. That strobe releases the freeze and drops the interrupt, and it keeps the error record. Sleep entry, shutdown and software reset clear the status as well. The active-low reset acts as the power-on reset.

Top module: `sticky_status_irq`

## Requirements
- R1: After reset the status word (address 0x18), the mask word (address 0x19) and the control word (address 0x1A) all read 0, and irq_n is 1.
- R2: A capture sets status bit k for a data-ready pulse on channel k (bits 3:0) and bit 8+j for an error pulse of kind j (bits 11:8). When the status holds no error flag, a capture that carries an error also loads err_chan_in into bits 15:14.
- R3: Once a capture has occurred, the status word stays unchanged and new pulses are dropped until a release (R6, R7, R9, R10).
- R4: irq_n goes low on a capture only if at least one captured flag has its mask bit set. Mask bits sit at the same positions as the status flags.
- R5: While control bit 0 is 1, irq_n is held at 1. Clearing the bit shows any pending interrupt again.
- R6: A read of 0x18 returns the status word on reg_rdata one cycle later, clears all flags and the channel field, releases the freeze and sets irq_n to 1.
- R7: A pulse on data_msb_rd releases the freeze, clears the data-ready flags and sets irq_n to 1. The error flags and the channel field stay as they are.
- R8: The channel field is not overwritten while any error flag is still set, even after a release by data_msb_rd.
- R9: sleep_enter and shutdown each clear the status word and the interrupt, and leave the mask and control words as they are.
- R10: sw_reset clears the status word, the interrupt, the mask word and the control word.
- R11: When a release and a new pulse fall in the same cycle, the release wins and the pulse is lost. A pulse still present on the next cycle is captured then.
- R12: Writes to 0x18 have no effect. Mask bits outside 3:0 and 11:8, and control bits other than bit 0, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| ready_pulse | input | 4 | Per-channel data-ready pulses |
| err_pulse | input | 4 | Per-kind error pulses |
| err_chan_in | input | 2 | Channel that raised the error pulses |
| sleep_enter | input | 1 | Pulse on entry to sleep |
| shutdown | input | 1 | Pulse on entry to shutdown |
| sw_reset | input | 1 | Software reset pulse |
| data_msb_rd | input | 1 | Pulse when a channel data-MSB register is read |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Captures are tried with a masked-out ready pulse, a masked-out error, and a mixed ready-plus-error pulse. This separates freezing from interrupt raising and shows that the mask gates only the pin. A second pulse sent while frozen shows that pulses are dropped. A release by data_msb_rd followed by an error from another channel shows that the channel record is kept. Each release path is driven alone, and the status read is also driven in the same cycle as a pulse of one and of two cycles, which shows the release wins and that only a lasting pulse is seen.

// File: rtl/sic_pkg.sv
`timescale 1ns/1ps
package sic_pkg;

    localparam int REG_W     = 16;
    localparam int READY_LSB = 0;
    localparam int ERR_LSB   = 8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic mode_clr;  // sleep, shutdown or software reset
        logic rd_clr;    // status word read
        logic msb_clr;   // channel data-MSB read
    } clr_t;

    // Bit positions in the status/mask words that carry a flag.
    function automatic logic [REG_W-1:0] flag_bits(input int nch, input int nerr);
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i < nch; i++) v[READY_LSB + i] = 1'b1;
        for (int j = 0; j < nerr; j++) v[ERR_LSB + j] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sic_reg_decode.sv
`timescale 1ns/1ps
module sic_reg_decode
    import sic_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int STATUS_ADDR  = 'h18,
    parameter int MASK_ADDR    = 'h19,
    parameter int CTRL_ADDR    = 'h1A
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output reg_sel_e          sel,
    output logic              wr_mask,
    output logic              wr_ctrl,
    output logic              rd_status
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_ADDR);

    always_comb begin
        sel = SEL_NONE;
        if (addr == A_STATUS)    sel = SEL_STATUS;
        else if (addr == A_MASK) sel = SEL_MASK;
        else if (addr == A_CTRL) sel = SEL_CTRL;
        wr_mask   = wr && (sel == SEL_MASK);
        wr_ctrl   = wr && (sel == SEL_CTRL);
        rd_status = rd && (sel == SEL_STATUS);
    end

endmodule

// File: rtl/sic_cfg_regs.sv
`timescale 1ns/1ps
module sic_cfg_regs
    import sic_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_ERR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             wr_mask,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask,
    output logic             irq_dis
);

    localparam logic [REG_W-1:0] FLAGS = flag_bits(NUM_CH, NUM_ERR);

    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic             dis;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sw_reset) begin
            cfg_d = '0;
        end else begin
            if (wr_mask) cfg_d.mask = wdata & FLAGS;
            if (wr_ctrl) cfg_d.dis  = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mask    = cfg_q.mask;
    assign irq_dis = cfg_q.dis;

endmodule

// File: rtl/sic_status_core.sv
`timescale 1ns/1ps
module sic_status_core
    import sic_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_ERR = 4,
    parameter int CHW     = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  ready_pulse,
    input  logic [NUM_ERR-1:0] err_pulse,
    input  logic [CHW-1:0]     err_chan_in,
    input  clr_t               clr,
    input  logic [REG_W-1:0]   mask,
    output logic [REG_W-1:0]   status,
    output logic               hold,
    output logic               irq
);

    typedef struct packed {
        logic [NUM_ERR-1:0] err;
        logic [NUM_CH-1:0]  rdy;
        logic [CHW-1:0]     chan;
        logic               hold;
        logic               irq;
    } st_t;

    st_t st_d, st_q;

    logic               any_pulse;
    logic               hit_mask;
    logic [NUM_CH-1:0]  rdy_en;
    logic [NUM_ERR-1:0] err_en;

    // Per-flag enable taken from the mask word at the flag's own position.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_rdy_en
        assign rdy_en[k] = mask[READY_LSB + k];
    end
    for (genvar j = 0; j < NUM_ERR; j++) begin : g_err_en
        assign err_en[j] = mask[ERR_LSB + j];
    end

    always_comb begin
        any_pulse = (|ready_pulse) || (|err_pulse);
        hit_mask  = (|(ready_pulse & rdy_en)) || (|(err_pulse & err_en));
        st_d      = st_q;
        if (clr.mode_clr || clr.rd_clr) begin
            st_d = '0;
        end else if (clr.msb_clr) begin
            st_d.rdy  = '0;
            st_d.hold = 1'b0;
            st_d.irq  = 1'b0;
        end else if (!st_q.hold && any_pulse) begin
            st_d.rdy  = st_q.rdy | ready_pulse;
            st_d.err  = st_q.err | err_pulse;
            if ((|err_pulse) && !(|st_q.err)) st_d.chan = err_chan_in;
            st_d.hold = 1'b1;
            st_d.irq  = hit_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status = '0;
        status[READY_LSB +: NUM_CH] = st_q.rdy;
        status[ERR_LSB +: NUM_ERR]  = st_q.err;
        status[REG_W-1 -: CHW]      = st_q.chan;
    end

    assign hold = st_q.hold;
    assign irq  = st_q.irq;

endmodule

// File: rtl/sticky_status_irq.sv
`timescale 1ns/1ps
module sticky_status_irq
    import sic_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NUM_ERR     = 4,
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 'h18,
    parameter int MASK_ADDR   = 'h19,
    parameter int CTRL_ADDR   = 'h1A,
    parameter int CHW         = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [15:0]        reg_wdata,
    input  logic               reg_wr,
    input  logic               reg_rd,
    output logic [15:0]        reg_rdata,
    input  logic [NUM_CH-1:0]  ready_pulse,
    input  logic [NUM_ERR-1:0] err_pulse,
    input  logic [CHW-1:0]     err_chan_in,
    input  logic               sleep_enter,
    input  logic               shutdown,
    input  logic               sw_reset,
    input  logic               data_msb_rd,
    output logic               irq_n
);

    reg_sel_e         sel;
    logic             wr_mask;
    logic             wr_ctrl;
    logic             rd_status;
    logic [REG_W-1:0] mask;
    logic             irq_dis;
    logic [REG_W-1:0] status;
    logic             hold;
    logic             irq;
    clr_t             clr;

    sic_reg_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .MASK_ADDR   (MASK_ADDR),
        .CTRL_ADDR   (CTRL_ADDR)
    ) u_dec (
        .addr      (reg_addr),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .sel       (sel),
        .wr_mask   (wr_mask),
        .wr_ctrl   (wr_ctrl),
        .rd_status (rd_status)
    );

    sic_cfg_regs #(
        .NUM_CH  (NUM_CH),
        .NUM_ERR (NUM_ERR)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_reset (sw_reset),
        .wr_mask  (wr_mask),
        .wr_ctrl  (wr_ctrl),
        .wdata    (reg_wdata),
        .mask     (mask),
        .irq_dis  (irq_dis)
    );

    always_comb begin
        clr.mode_clr = sleep_enter || shutdown || sw_reset;
        clr.rd_clr   = rd_status;
        clr.msb_clr  = data_msb_rd;
    end

    sic_status_core #(
        .NUM_CH  (NUM_CH),
        .NUM_ERR (NUM_ERR),
        .CHW     (CHW)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_pulse (ready_pulse),
        .err_pulse   (err_pulse),
        .err_chan_in (err_chan_in),
        .clr         (clr),
        .mask        (mask),
        .status      (status),
        .hold        (hold),
        .irq         (irq)
    );

    // Read data path
    logic [REG_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (reg_rd) begin
            unique case (sel)
                SEL_STATUS: rdata_d = status;
                SEL_MASK:   rdata_d = mask;
                SEL_CTRL:   rdata_d = {{(REG_W-1){1'b0}}, irq_dis};
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign reg_rdata = rdata_q;
    assign irq_n     = !(irq && !irq_dis);

endmodule

// File: rtl/sic_status_chk.sv
`timescale 1ns/1ps
module sic_status_chk
    import sic_pkg::*;
#(
    parameter int NUM_ERR = 4,
    parameter int CHW     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_n,
    input logic [REG_W-1:0] status,
    input logic             hold,
    input logic             irq,
    input clr_t             clr
);

    // R3
    frozen_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr.mode_clr && !clr.rd_clr && !clr.msb_clr) |=> $stable(status));

    // R6
    read_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr.rd_clr |=> (status == '0 && irq_n));

    // R4
    irq_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hold);

    // R11
    release_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr.mode_clr || clr.rd_clr || clr.msb_clr) |=> !hold);

    // R8
    chan_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|status[ERR_LSB +: NUM_ERR]) && !clr.mode_clr && !clr.rd_clr)
        |=> $stable(status[REG_W-1 -: CHW]));

    // R9
    mode_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr.mode_clr |=> (status == '0 && irq_n));

endmodule

bind sticky_status_irq sic_status_chk #(
    .NUM_ERR (NUM_ERR),
    .CHW     (CHW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_n  (irq_n),
    .status (status),
    .hold   (hold),
    .irq    (irq),
    .clr    (clr)
);

// File: tb/sticky_status_irq_tb.sv
`timescale 1ns/1ps
module sticky_status_irq_tb;

    localparam logic [7:0] A_ST = 8'h18;
    localparam logic [7:0] A_MK = 8'h19;
    localparam logic [7:0] A_CT = 8'h1A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic [3:0]  ready_pulse = '0;
    logic [3:0]  err_pulse = '0;
    logic [1:0]  err_chan_in = '0;
    logic        sleep_enter = 1'b0;
    logic        shutdown = 1'b0;
    logic        sw_reset = 1'b0;
    logic        data_msb_rd = 1'b0;
    logic        irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sticky_status_irq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .ready_pulse(ready_pulse), .err_pulse(err_pulse), .err_chan_in(err_chan_in),
        .sleep_enter(sleep_enter), .shutdown(shutdown), .sw_reset(sw_reset),
        .data_msb_rd(data_msb_rd), .irq_n(irq_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic ev(input logic [3:0] r, input logic [3:0] e, input logic [1:0] c);
        ready_pulse = r; err_pulse = e; err_chan_in = c;
        tick();
        ready_pulse = '0; err_pulse = '0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
        rd_reg(A_ST, v); chk("R1 status", v, 16'h0000);
        rd_reg(A_MK, v); chk("R1 mask", v, 16'h0000);
        rd_reg(A_CT, v); chk("R1 ctrl", v, 16'h0000);
    endtask

    task automatic t_mask_capture();
        logic [15:0] v;
        ev(4'b0100, 4'b0000, 2'd0);
        chk("R4 unmasked ready keeps irq_n", {15'd0, irq_n}, 16'd1);
        rd_reg(A_ST, v); chk("R2 ready ch2", v, 16'h0004);
        wr_reg(A_MK, 16'h0100);
        ev(4'b0000, 4'b0010, 2'd3);
        chk("R4 masked-off error", {15'd0, irq_n}, 16'd1);
        rd_reg(A_ST, v); chk("R2 err kind1 chan3", v, 16'hC200);
        ev(4'b0001, 4'b0001, 2'd1);
        chk("R4 enabled error drives irq", {15'd0, irq_n}, 16'd0);
        rd_reg(A_ST, v); chk("R2 mixed capture", v, 16'h4101);
        chk("R6 irq released", {15'd0, irq_n}, 16'd1);
    endtask

    task automatic t_freeze();
        logic [15:0] v;
        wr_reg(A_MK, 16'hFFFF);
        rd_reg(A_MK, v); chk("R12 mask unused bits", v, 16'h0F0F);
        ev(4'b0010, 4'b0000, 2'd0);
        chk("R4 irq low", {15'd0, irq_n}, 16'd0);
        ev(4'b0000, 4'b0100, 2'd2);
        rd_reg(A_ST, v); chk("R3 later pulse dropped", v, 16'h0002);
        rd_reg(A_ST, v); chk("R6 read wipes", v, 16'h0000);
    endtask

    task automatic t_disable();
        logic [15:0] v;
        ev(4'b1000, 4'b0000, 2'd0);
        chk("R4 pending", {15'd0, irq_n}, 16'd0);
        wr_reg(A_CT, 16'hFFFF);
        chk("R5 disable forces high", {15'd0, irq_n}, 16'd1);
        rd_reg(A_CT, v); chk("R12 ctrl bit0 only", v, 16'h0001);
        wr_reg(A_CT, 16'h0000);
        chk("R5 pending shows again", {15'd0, irq_n}, 16'd0);
        rd_reg(A_ST, v); chk("R6 read value", v, 16'h0008);
        chk("R6 irq released", {15'd0, irq_n}, 16'd1);
    endtask

    task automatic t_msb_release();
        logic [15:0] v;
        ev(4'b0001, 4'b0001, 2'd1);
        chk("R4 irq low", {15'd0, irq_n}, 16'd0);
        data_msb_rd = 1'b1; tick(); data_msb_rd = 1'b0;
        chk("R7 irq released", {15'd0, irq_n}, 16'd1);
        ev(4'b0000, 4'b1000, 2'd2);
        chk("R7 capture after release", {15'd0, irq_n}, 16'd0);
        rd_reg(A_ST, v); chk("R8 R7 chan kept, ready wiped", v, 16'h4900);
    endtask

    task automatic t_modes();
        logic [15:0] v;
        ev(4'b0001, 4'b0000, 2'd0);
        sleep_enter = 1'b1; tick(); sleep_enter = 1'b0;
        chk("R9 sleep irq", {15'd0, irq_n}, 16'd1);
        rd_reg(A_ST, v); chk("R9 sleep status", v, 16'h0000);
        ev(4'b0000, 4'b0001, 2'd2);
        shutdown = 1'b1; tick(); shutdown = 1'b0;
        chk("R9 shutdown irq", {15'd0, irq_n}, 16'd1);
        rd_reg(A_ST, v); chk("R9 shutdown status", v, 16'h0000);
        rd_reg(A_MK, v); chk("R9 mask kept", v, 16'h0F0F);
    endtask

    task automatic t_swreset();
        logic [15:0] v;
        wr_reg(A_CT, 16'h0001);
        ev(4'b0010, 4'b0000, 2'd0);
        sw_reset = 1'b1; tick(); sw_reset = 1'b0;
        rd_reg(A_ST, v); chk("R10 status", v, 16'h0000);
        rd_reg(A_MK, v); chk("R10 mask", v, 16'h0000);
        rd_reg(A_CT, v); chk("R10 ctrl", v, 16'h0000);
        wr_reg(A_MK, 16'h0F0F);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        ready_pulse = 4'b0001; reg_addr = A_ST; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0; ready_pulse = '0;
        chk("R11 one-cycle pulse lost irq", {15'd0, irq_n}, 16'd1);
        rd_reg(A_ST, v); chk("R11 one-cycle pulse lost", v, 16'h0000);
        ready_pulse = 4'b0001; reg_addr = A_ST; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        tick();
        ready_pulse = '0;
        chk("R11 lasting pulse irq", {15'd0, irq_n}, 16'd0);
        rd_reg(A_ST, v); chk("R11 lasting pulse captured", v, 16'h0001);
    endtask

    task automatic t_status_write();
        logic [15:0] v;
        ev(4'b0010, 4'b0000, 2'd0);
        wr_reg(A_ST, 16'h0000);
        rd_reg(A_ST, v); chk("R12 write ignored", v, 16'h0002);
        wr_reg(A_ST, 16'hFFFF);
        rd_reg(A_ST, v); chk("R12 write sets nothing", v, 16'h0000);
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mask_capture();
        t_freeze();
        t_disable();
        t_msb_release();
        t_modes();
        t_swreset();
        t_collision();
        t_status_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule